// File: doc/BRIEF.md
# Timer-Paced DMA Sample Playback Sequencer

This block streams 8-bit audio samples from a host DMA channel to a DAC at a programmable rate. An 8-bit auto-reload rate timer advances on a 1 MHz tick strobe. Each time it wraps, the sequencer raises a one-cycle DMA request and waits for the byte. It then drives that byte onto the DAC and counts down the remaining samples.

When the count runs out, the block picks one of three outcomes in a fixed order of precedence. A pending exit request ends the transfer. Otherwise a length queued while the transfer was running is chained in. Otherwise the block reloads from the block-size setting if auto-init is active, and stops if it is not. Every outcome pulses the active-low host interrupt. A pending host command makes the block skip a sample slot. Pause and continue strobes freeze and resume the transfer without touching the count.

Top module: `dma_play_seq`

## Requirements
- R1: After reset, `irq_no` is 1, `dreq_o` is 0, `dma_en_no` is 1, `busy_o` is 0 and `dac_o` is 0.
- R2: A start loads the rate counter with `tconst_i`. Each tick strobe increments it, and a tick that finds it at 0xFF reloads it and opens a sample slot. The first request therefore follows 256 − `tconst_i` ticks after the start, and later requests come at the same spacing.
- R3: A start while `dma_en_no` is 1 sets `busy_o` to 1 and `dma_en_no` to 0 in the next cycle. It loads the sample count from `start_len_i`, or from `blk_len_i` when `auto_init_i` is 1. A count of N gives N samples.
- R4: Each sample slot drives `busy_o` to 1 and raises `dreq_o` while DMA is enabled. The byte on `data_i` is taken in the first cycle from then on with `data_valid_i` high, and appears on `dac_o` one cycle later. `dac_o` changes at no other time.
- R5: Two cycles after `data_valid_i` delivers a byte, `busy_o` is 0. If samples remain, `irq_no` stays high.
- R6: A slot that opens while `cmd_pend_i` is 1 is dropped: no request, no DAC change and no count change.
- R7: At count end with an exit request recorded, the transfer stops even when a queued length or auto-init is present.
- R8: A plain start while `dma_en_no` is 0 queues its length and does not disturb the running count. At count end without exit, the queued length is loaded, auto-init is cleared, `irq_no` pulses and the transfer continues.
- R9: With auto-init set and neither exit nor a queued length, count end reloads from `blk_len_i`, pulses `irq_no` and continues. A start with `auto_init_i` at 1 while DMA is enabled only sets auto-init.
- R10: A single-shot end stops the timer and pulses `irq_no` low in the same cycle that `dma_en_no` returns to 1. `busy_o` then ends at 0. `irq_no` pulses only while DMA was enabled in the cycle before.
- R11: Every `dreq_o` high pulse and every `irq_no` low pulse lasts exactly one clock cycle.
- R12: `pause_i` sets `dma_en_no` to 1 and halts the timer, keeping the count. `continue_i` after a pause sets `dma_en_no` to 0 and restarts the timer. No requests are issued while paused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 MHz tick strobe, one clock wide |
| tconst_i | input | 8 | Rate timer reload value |
| blk_len_i | input | 16 | Auto-init block length |
| start_i | input | 1 | Start or queue strobe |
| start_len_i | input | 16 | Length sent with a start |
| auto_init_i | input | 1 | Start selects auto-init mode |
| exit_ai_i | input | 1 | Request to end auto-init at count end |
| pause_i | input | 1 | Pause strobe |
| continue_i | input | 1 | Continue strobe |
| cmd_pend_i | input | 1 | Host command waiting; slots are skipped |
| dreq_o | output | 1 | DMA request pulse, active high |
| data_valid_i | input | 1 | DMA byte present on data_i |
| data_i | input | 8 | DMA sample byte |
| dac_o | output | 8 | DAC sample |
| busy_o | output | 1 | Busy flag to host |
| dma_en_no | output | 1 | DMA enable, active low |
| irq_no | output | 1 | Host interrupt pulse, active low |

## Verification
A slot opens on the clock edge where a tick finds the rate counter at 0xFF, and `dreq_o` is high during the following cycle. A byte accepted at edge E shows on `dac_o` after E, and `busy_o` falls and any interrupt pulse appears after E+1. The monitor samples on the falling edge and keeps this pipeline as one-cycle pending flags: it checks the DAC value one falling edge after it answered a request, and the busy flag one edge after that. Interrupt pulses are classified at the falling edge where they are seen, using `dma_en_no` at that same edge, and matched against an ordered queue of expected events. Tick counts between requests are compared against 256 − `tconst_i`.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_REQ,
    ST_WAIT,
    ST_EVAL
  } seq_state_e;

  typedef enum logic [1:0] {
    END_STOP,
    END_CHAIN,
    END_RELOAD
  } end_act_e;
endpackage

// File: rtl/dps_rate_timer.sv
module dps_rate_timer #(
  parameter int TC_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            load_i,
  input  logic [TC_W-1:0] tconst_i,
  output logic            fire_o
);
  localparam logic [TC_W-1:0] CntTop = {TC_W{1'b1}};

  logic [TC_W-1:0] cnt_q;
  logic            wrap;

  assign wrap   = (cnt_q == CntTop);
  assign fire_o = run_i && tick_i && !load_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= tconst_i;
    end else if (run_i && tick_i) begin
      cnt_q <= wrap ? tconst_i : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dps_len_ctrl.sv
module dps_len_ctrl
  import dps_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_idle_i,
  input  logic             start_busy_i,
  input  logic             auto_init_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] blk_i,
  input  logic             exit_set_i,
  input  logic             dec_i,
  input  logic             apply_end_i,
  output logic             cnt_zero_o,
  output end_act_e         end_act_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] shadow_q;
  logic             queued_q;
  logic             ai_q;
  logic             exit_q;

  assign cnt_zero_o = (cnt_q == '0);

  // fixed precedence: exit, then queued length, then auto-init
  always_comb begin
    if (exit_q)        end_act_o = END_STOP;
    else if (queued_q) end_act_o = END_CHAIN;
    else if (ai_q)     end_act_o = END_RELOAD;
    else               end_act_o = END_STOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      queued_q <= 1'b0;
      ai_q     <= 1'b0;
      exit_q   <= 1'b0;
    end else if (start_idle_i) begin
      cnt_q    <= auto_init_i ? blk_i : len_i;
      ai_q     <= auto_init_i;
      queued_q <= 1'b0;
      exit_q   <= 1'b0;
    end else begin
      if (dec_i) cnt_q <= cnt_q - 1'b1;
      if (apply_end_i) begin
        unique case (end_act_o)
          END_CHAIN: begin
            cnt_q    <= shadow_q;
            queued_q <= 1'b0;
            ai_q     <= 1'b0;
          end
          END_RELOAD: cnt_q <= blk_i;
          default: begin
            exit_q   <= 1'b0;
            queued_q <= 1'b0;
            ai_q     <= 1'b0;
          end
        endcase
      end
      // a new queue request wins over a same-cycle chain
      if (start_busy_i) begin
        if (auto_init_i) begin
          ai_q <= 1'b1;
        end else begin
          shadow_q <= len_i;
          queued_q <= 1'b1;
        end
      end
      if (exit_set_i) exit_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dps_seq_fsm.sv
module dps_seq_fsm
  import dps_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              exit_ai_i,
  input  logic              pause_i,
  input  logic              continue_i,
  input  logic              cmd_pend_i,
  input  logic              fire_i,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cnt_zero_i,
  input  end_act_e          end_act_i,
  output logic              start_idle_o,
  output logic              start_busy_o,
  output logic              exit_set_o,
  output logic              dec_o,
  output logic              apply_end_o,
  output logic              timer_run_o,
  output logic              dreq_o,
  output logic [DATA_W-1:0] dac_o,
  output logic              busy_o,
  output logic              dma_en_no,
  output logic              irq_no
);
  seq_state_e        state_q;
  logic              busy_q;
  logic              dreq_q;
  logic              irq_nq;
  logic              dma_en_nq;
  logic              run_q;
  logic              paused_q;
  logic [DATA_W-1:0] dac_q;
  logic              take;
  logic              stop_now;

  assign start_idle_o = start_i && dma_en_nq && (state_q == ST_IDLE || state_q == ST_RUN);
  assign start_busy_o = start_i && !dma_en_nq;
  assign exit_set_o   = exit_ai_i && (state_q != ST_IDLE);
  assign take         = data_valid_i && (state_q == ST_REQ || state_q == ST_WAIT);
  assign dec_o        = take;
  assign apply_end_o  = (state_q == ST_EVAL) && cnt_zero_i;
  assign stop_now     = apply_end_o && (end_act_i == END_STOP);
  assign timer_run_o  = run_q;

  assign dreq_o    = dreq_q;
  assign dac_o     = dac_q;
  assign busy_o    = busy_q;
  assign dma_en_no = dma_en_nq;
  assign irq_no    = irq_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      busy_q    <= 1'b0;
      dreq_q    <= 1'b0;
      irq_nq    <= 1'b1;
      dma_en_nq <= 1'b1;
      run_q     <= 1'b0;
      paused_q  <= 1'b0;
      dac_q     <= '0;
    end else begin
      dreq_q <= 1'b0;
      irq_nq <= 1'b1;
      if (take) dac_q <= data_i;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q   <= ST_RUN;
            busy_q    <= 1'b1;
            dma_en_nq <= 1'b0;
            run_q     <= 1'b1;
            paused_q  <= 1'b0;
          end
        end
        ST_RUN: begin
          if (start_idle_o) begin
            busy_q    <= 1'b1;
            dma_en_nq <= 1'b0;
            run_q     <= 1'b1;
            paused_q  <= 1'b0;
          end else if (fire_i && !cmd_pend_i && !pause_i) begin
            state_q <= ST_REQ;
            busy_q  <= 1'b1;
            dreq_q  <= 1'b1;
          end
        end
        ST_REQ:  state_q <= take ? ST_EVAL : ST_WAIT;
        ST_WAIT: if (take) state_q <= ST_EVAL;
        ST_EVAL: begin
          busy_q <= 1'b0;
          if (cnt_zero_i) irq_nq <= 1'b0;
          if (stop_now) begin
            state_q   <= ST_IDLE;
            run_q     <= 1'b0;
            dma_en_nq <= 1'b1;
            paused_q  <= 1'b0;
          end else begin
            state_q <= ST_RUN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      // pause has the last word; continue only revives a paused transfer
      if (pause_i) begin
        run_q     <= 1'b0;
        dma_en_nq <= 1'b1;
        paused_q  <= 1'b1;
      end else if (continue_i && paused_q && state_q != ST_IDLE && !stop_now) begin
        run_q     <= 1'b1;
        dma_en_nq <= 1'b0;
        paused_q  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_play_seq.sv
module dma_play_seq
  import dps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 16,
  parameter int TC_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [TC_W-1:0]   tconst_i,
  input  logic [LEN_W-1:0]  blk_len_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              auto_init_i,
  input  logic              exit_ai_i,
  input  logic              pause_i,
  input  logic              continue_i,
  input  logic              cmd_pend_i,
  output logic              dreq_o,
  input  logic              data_valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] dac_o,
  output logic              busy_o,
  output logic              dma_en_no,
  output logic              irq_no
);
  logic     start_idle;
  logic     start_busy;
  logic     exit_set;
  logic     dec;
  logic     apply_end;
  logic     timer_run;
  logic     fire;
  logic     cnt_zero;
  end_act_e end_act;

  dps_rate_timer #(.TC_W(TC_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (timer_run),
    .load_i   (start_idle),
    .tconst_i (tconst_i),
    .fire_o   (fire)
  );

  dps_len_ctrl #(.LEN_W(LEN_W)) u_len (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_idle_i (start_idle),
    .start_busy_i (start_busy),
    .auto_init_i  (auto_init_i),
    .len_i        (start_len_i),
    .blk_i        (blk_len_i),
    .exit_set_i   (exit_set),
    .dec_i        (dec),
    .apply_end_i  (apply_end),
    .cnt_zero_o   (cnt_zero),
    .end_act_o    (end_act)
  );

  dps_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .exit_ai_i    (exit_ai_i),
    .pause_i      (pause_i),
    .continue_i   (continue_i),
    .cmd_pend_i   (cmd_pend_i),
    .fire_i       (fire),
    .data_valid_i (data_valid_i),
    .data_i       (data_i),
    .cnt_zero_i   (cnt_zero),
    .end_act_i    (end_act),
    .start_idle_o (start_idle),
    .start_busy_o (start_busy),
    .exit_set_o   (exit_set),
    .dec_o        (dec),
    .apply_end_o  (apply_end),
    .timer_run_o  (timer_run),
    .dreq_o       (dreq_o),
    .dac_o        (dac_o),
    .busy_o       (busy_o),
    .dma_en_no    (dma_en_no),
    .irq_no       (irq_no)
  );
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dreq_o,
  input logic              irq_no,
  input logic              dma_en_no,
  input logic              busy_o,
  input logic              pause_i,
  input logic              data_valid_i,
  input logic [DATA_W-1:0] dac_o
);
  AST_DREQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |=> !dreq_o); // R11

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |=> irq_no); // R11

  AST_DREQ_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_o |-> (!dma_en_no && busy_o)); // R4

  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(data_valid_i) |-> $stable(dac_o)); // R4

  AST_IRQ_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> !$past(dma_en_no)); // R10

  AST_PAUSE_MASKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_i |=> dma_en_no); // R12
endmodule

bind dma_play_seq dps_checker #(.DATA_W(DATA_W)) u_dps_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dreq_o       (dreq_o),
  .irq_no       (irq_no),
  .dma_en_no    (dma_en_no),
  .busy_o       (busy_o),
  .pause_i      (pause_i),
  .data_valid_i (data_valid_i),
  .dac_o        (dac_o)
);

// File: tb/dma_play_seq_bench.sv
module dma_play_seq_bench;
  typedef enum int {EV_SAMPLE, EV_GO, EV_STOP} ev_e;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [7:0]  tconst_i = 8'hFC;
  logic [15:0] blk_len_i = 16'd2;
  logic        start_i = 1'b0;
  logic [15:0] start_len_i = '0;
  logic        auto_init_i = 1'b0;
  logic        exit_ai_i = 1'b0;
  logic        pause_i = 1'b0;
  logic        continue_i = 1'b0;
  logic        cmd_pend_i = 1'b0;
  logic        dreq_o;
  logic        data_valid_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [7:0]  dac_o;
  logic        busy_o;
  logic        dma_en_no;
  logic        irq_no;

  always #5 clk_i = ~clk_i;

  dma_play_seq u_dma_play_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .tconst_i(tconst_i),
    .blk_len_i(blk_len_i), .start_i(start_i), .start_len_i(start_len_i),
    .auto_init_i(auto_init_i), .exit_ai_i(exit_ai_i), .pause_i(pause_i),
    .continue_i(continue_i), .cmd_pend_i(cmd_pend_i), .dreq_o(dreq_o),
    .data_valid_i(data_valid_i), .data_i(data_i), .dac_o(dac_o),
    .busy_o(busy_o), .dma_en_no(dma_en_no), .irq_no(irq_no)
  );

  ev_e   exp_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    sample_cnt = 0;
  int    irq_cnt = 0;
  int    dreq_cnt = 0;
  int    tick_cnt = 0;
  bit    period_chk = 1'b0;
  bit    dac_pend = 1'b0;
  bit    busy_pend = 1'b0;
  bit    prev_dreq = 1'b0;
  bit    prev_irq_low = 1'b0;
  string cur_req = "R10";
  logic [7:0] feed = 8'h40;
  logic [7:0] last_fed = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pop_cmp(input ev_e got);
    if (exp_q.size() == 0) begin
      chk(1'b0, {cur_req, " unexpected event"}, int'(got), -1);
    end else begin
      ev_e e = exp_q.pop_front();
      chk(e == got, {cur_req, " event order"}, int'(got), int'(e));
    end
  endtask

  // tick strobe every 4 clocks
  initial begin
    forever begin
      repeat (3) @(posedge clk_i);
      #1 tick_i = 1'b1;
      @(posedge clk_i);
      #1 tick_i = 1'b0;
    end
  end

  // monitor: serves DMA bytes and compares observed events with the queue
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (busy_pend) begin
          chk(busy_o == 1'b0, "R5 busy after sample", busy_o, 0);
          busy_pend = 1'b0;
        end
        if (dac_pend) begin
          chk(dac_o == last_fed, "R4 dac value", dac_o, last_fed);
          data_valid_i = 1'b0;
          dac_pend = 1'b0;
          busy_pend = 1'b1;
          sample_cnt++;
        end
        if (start_i) begin
          tick_cnt = 0;
        end else if (dreq_o) begin
          if (period_chk) chk(tick_cnt == 256 - int'(tconst_i), "R2 tick spacing",
                              tick_cnt, 256 - int'(tconst_i));
          tick_cnt = 0;
        end else if (tick_i) begin
          tick_cnt++;
        end
        if (dreq_o) begin
          chk(!prev_dreq, "R11 dreq width", 2, 1);
          chk(busy_o == 1'b1, "R4 busy in slot", busy_o, 1);
          dreq_cnt++;
          pop_cmp(EV_SAMPLE);
          data_i = feed;
          last_fed = feed;
          feed = feed + 8'd3;
          data_valid_i = 1'b1;
          dac_pend = 1'b1;
        end
        if (!irq_no) begin
          chk(!prev_irq_low, "R11 irq width", 2, 1);
          pop_cmp(dma_en_no ? EV_STOP : EV_GO);
          irq_cnt++;
        end
        prev_dreq = dreq_o;
        prev_irq_low = !irq_no;
      end
    end
  end

  task automatic expect_ev(input ev_e e);
    exp_q.push_back(e);
  endtask

  task automatic do_start(input logic [15:0] len, input bit ai);
    @(posedge clk_i);
    #1;
    start_len_i = len;
    auto_init_i = ai;
    start_i = 1'b1;
    @(posedge clk_i);
    #1;
    start_i = 1'b0;
    auto_init_i = 1'b0;
  endtask

  task automatic pulse_exit();
    @(posedge clk_i);
    #1 exit_ai_i = 1'b1;
    @(posedge clk_i);
    #1 exit_ai_i = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk_i);
    while (!(dma_en_no && exp_q.size() == 0 && !dac_pend && !busy_pend));
    repeat (40) @(negedge clk_i);
    chk(busy_o == 1'b0 && dma_en_no == 1'b1, "R10 idle after stop", {busy_o, dma_en_no}, 1);
    chk(exp_q.size() == 0, {cur_req, " events outstanding"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    int d0;
    logic [7:0] dac_snap;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset values
    chk(irq_no == 1'b1, "R1 irq_no", irq_no, 1);
    chk(dreq_o == 1'b0, "R1 dreq_o", dreq_o, 0);
    chk(dma_en_no == 1'b1, "R1 dma_en_no", dma_en_no, 1);
    chk(busy_o == 1'b0, "R1 busy_o", busy_o, 0);
    chk(dac_o == 8'h00, "R1 dac_o", dac_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    // single shot, three samples, spacing checked (R3, R10)
    cur_req = "R10";
    period_chk = 1'b1;
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    do_start(16'd3, 1'b0);
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R3 busy on start", busy_o, 1);
    chk(dma_en_no == 1'b0, "R3 dma enable on start", dma_en_no, 0);
    wait_idle();

    // different time constant (R2)
    cur_req = "R2";
    tconst_i = 8'hFA;
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    do_start(16'd2, 1'b0);
    wait_idle();
    period_chk = 1'b0;
    tconst_i = 8'hFC;

    // queued length chains after the running count (R8)
    cur_req = "R8";
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_GO);
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    do_start(16'd2, 1'b0);
    wait (sample_cnt == base + 1);
    do_start(16'd3, 1'b0);
    wait_idle();

    // auto-init reload from block size, then exit (R9)
    cur_req = "R9";
    blk_len_i = 16'd2;
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_GO);
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_GO);
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = irq_cnt;
    do_start(16'd9, 1'b1);
    wait (irq_cnt == base + 2);
    pulse_exit();
    wait_idle();

    // queued length outranks auto-init and clears it (R8)
    cur_req = "R8";
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_GO);
    expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    do_start(16'd0, 1'b1);
    wait (sample_cnt == base + 1);
    do_start(16'd1, 1'b0);
    wait_idle();

    // exit outranks a queued length (R7)
    cur_req = "R7";
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    do_start(16'd0, 1'b1);
    wait (sample_cnt == base + 1);
    do_start(16'd5, 1'b0);
    pulse_exit();
    wait_idle();

    // auto-init start while running only sets the flag (R9)
    cur_req = "R9";
    blk_len_i = 16'd1;
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_GO);
    expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    d0 = irq_cnt;
    do_start(16'd2, 1'b0);
    wait (sample_cnt == base + 1);
    do_start(16'd0, 1'b1);
    wait (irq_cnt == d0 + 1);
    pulse_exit();
    wait_idle();

    // pending host command drops one slot (R6)
    cur_req = "R6";
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    do_start(16'd2, 1'b0);
    wait (sample_cnt == base + 1);
    @(posedge clk_i);
    #1 cmd_pend_i = 1'b1;
    d0 = dreq_cnt;
    dac_snap = dac_o;
    repeat (20) @(negedge clk_i);
    chk(dreq_cnt == d0, "R6 no request while pending", dreq_cnt - d0, 0);
    chk(dac_o == dac_snap, "R6 dac unchanged", dac_o, dac_snap);
    cmd_pend_i = 1'b0;
    wait_idle();

    // pause holds the count, continue resumes (R12)
    cur_req = "R12";
    expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_SAMPLE); expect_ev(EV_STOP);
    base = sample_cnt;
    do_start(16'd3, 1'b0);
    wait (sample_cnt == base + 1);
    @(posedge clk_i);
    #1 pause_i = 1'b1;
    @(posedge clk_i);
    #1 pause_i = 1'b0;
    @(negedge clk_i);
    chk(dma_en_no == 1'b1, "R12 pause masks DMA", dma_en_no, 1);
    d0 = dreq_cnt;
    repeat (40) @(negedge clk_i);
    chk(dreq_cnt == d0, "R12 no request while paused", dreq_cnt - d0, 0);
    @(posedge clk_i);
    #1 continue_i = 1'b1;
    @(posedge clk_i);
    #1 continue_i = 1'b0;
    @(negedge clk_i);
    chk(dma_en_no == 1'b0, "R12 continue enables DMA", dma_en_no, 0);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule